// File: doc/BRIEF.md
# CAN Receive Mailbox with Read Lock

This block is one receive message buffer of a CAN / CAN FD controller. A receiver front end, which is not part of this block, hands it each completed frame in one cycle: a valid strobe, a flag saying whether the acceptance filter matched, and the identifier, the frame flags (SRR, IDE, RTR, EDL, BRS, ESI), the DLC and up to 64 data bytes. A separate strobe marks the moment the timestamp must be taken, and the block latches the value of its own free-running timer at that point. Software activates the buffer by writing a code. It sees a frame arrive through an interrupt flag, and then services the frame through a small register window.

Reading the status word locks the buffer. While it is locked, no arriving frame can change what software is reading. A frame that completes during the lock waits in a one-deep holding register and moves in on the cycle after software releases the lock by reading the timer. A write to the status word while a frame is waiting throws that frame away, which is the frame loss that occurs when software forces a new code without first taking the buffer out of service safely.

Top module: `can_rx_mbox`

## Requirements
- R1: After reset the status word reads 0 (code INACTIVE = 4'b0000), the interrupt flag reads 0 and `irq` is low. While the code is INACTIVE, frames have no effect and the flag stays 0.
- R2: Writing the code field (status word bits [27:24]) makes the buffer active when the code is EMPTY (4'b0100), FULL or OVERRUN. A strobe with `rx_match` low has no effect.
- R3: A move-in stores the identifier, the flags, the DLC, the data and the timestamp. The timestamp is the timer value sampled at the `ts_cap` edge. Address map: 0 is the status word, 1 is the identifier in bits [28:0], 2 is the flag in bit 0, 3 is the mask in bit 0, 4 is the timer in bits [15:0], and 16+k is data word k, which holds bytes 4k..4k+3 with byte 4k in bits [7:0]. Status word layout: [31] EDL, [30] BRS, [29] ESI, [27:24] code, [23] BUSY, [22] SRR, [21] IDE, [20] RTR, [19:16] DLC, [15:0] timestamp.
- R4: On an unlocked buffer, a frame strobed at clock edge t is committed at edge t+1. BUSY reads 1 between those edges. After a commit into EMPTY the code is FULL (4'b0010).
- R5: A commit into a buffer whose code is FULL or OVERRUN gives OVERRUN (4'b0110).
- R6: Each commit sets the flag. `irq` is the flag ANDed with the mask. Writing 1 to flag bit 0 clears the flag, and a commit in the same cycle wins over the clear.
- R7: A status-word read with BUSY low locks the buffer. While it is locked, the stored contents do not change.
- R8: A timer read unlocks the buffer. A frame held during the lock is committed on the cycle after the unlock.
- R9: A second frame that arrives while one is held replaces it, and its commit gives OVERRUN.
- R10: A status-word write while a frame is held discards that frame. The stored contents and the flag are left unchanged.
- R11: After servicing (a status read, then a timer read), the code stays FULL.
- R12: A status-word read while BUSY is 1 does not lock the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A completed frame is presented this cycle |
| rx_match | input | 1 | The acceptance filter matched this frame |
| rx_id | input | 29 | Frame identifier |
| rx_srr | input | 1 | SRR bit |
| rx_ide | input | 1 | Extended-identifier bit |
| rx_rtr | input | 1 | Remote-request bit |
| rx_edl | input | 1 | FD format bit |
| rx_brs | input | 1 | Bit-rate-switch bit |
| rx_esi | input | 1 | Error-state bit |
| rx_dlc | input | 4 | Data length code |
| rx_data | input | DATA_BYTES*8 | Data bytes, byte j in bits [8j+7:8j] |
| ts_cap | input | 1 | Latch the timer as the pending timestamp |
| cpu_addr | input | ADDR_W | Register word address |
| cpu_rd | input | 1 | Register read strobe (has side effects) |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, combinational from `cpu_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high together and that a strobe reaches only one address. They also assume that `rx_valid` is a one-cycle pulse whose payload is stable in that cycle. The bench drives every input at the falling edge through tasks that raise exactly one strobe for exactly one cycle. It sets up locks, held frames and clears in a fixed order, so that every combination of commit, lock, unlock and status write that the properties relate comes from legal register traffic.

// File: rtl/can_mbox_pkg.sv
// Shared constants and types for the receive mailbox.
package can_mbox_pkg;
    localparam int ID_W = 29;
    localparam int TS_W = 16;

    localparam logic [3:0] CODE_INACTIVE = 4'b0000;
    localparam logic [3:0] CODE_EMPTY    = 4'b0100;
    localparam logic [3:0] CODE_FULL     = 4'b0010;
    localparam logic [3:0] CODE_OVERRUN  = 4'b0110;

    // Frame control fields carried along with the identifier.
    typedef struct packed {
        logic       srr;
        logic       ide;
        logic       rtr;
        logic       edl;
        logic       brs;
        logic       esi;
        logic [3:0] dlc;
    } mb_ctl_t;
endpackage

// File: rtl/mbox_pend.sv
// One-deep holding register between the receiver and the mailbox store.
// Assumes load, take and drop come from mbox_ctrl. Drop wins over load,
// and load wins over take. The replace tag marks a frame that overwrote
// an uncommitted one.
module mbox_pend
    import can_mbox_pkg::*;
#(
    parameter int DW = 512
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            take_i,
    input  logic            drop_i,
    input  logic [ID_W-1:0] id_i,
    input  mb_ctl_t         ctl_i,
    input  logic [DW-1:0]   data_i,
    input  logic [TS_W-1:0] ts_i,
    output logic            valid_o,
    output logic            ovr_o,
    output logic [ID_W-1:0] id_o,
    output mb_ctl_t         ctl_o,
    output logic [DW-1:0]   data_o,
    output logic [TS_W-1:0] ts_o
);
    // Occupancy and replace tag of the holding slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            ovr_o   <= 1'b0;
        end else if (drop_i) begin
            valid_o <= 1'b0;
            ovr_o   <= 1'b0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            ovr_o   <= valid_o && !take_i;
        end else if (take_i) begin
            valid_o <= 1'b0;
            ovr_o   <= 1'b0;
        end
    end

    // Payload capture; the contents matter only while valid_o is set.
    always_ff @(posedge clk) begin
        if (load_i) begin
            id_o   <= id_i;
            ctl_o  <= ctl_i;
            data_o <= data_i;
            ts_o   <= ts_i;
        end
    end

    AST_REPLACE_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && load_i && !take_i && !drop_i) |=> ovr_o); // R9
endmodule

// File: rtl/mbox_ctrl.sv
// Mailbox sequencing: code field, read lock, busy, commit, interrupt flag
// and mask, free-running timer and the timestamp shadow.
// Assumes the strobes are decoded from one CPU access per cycle.
module mbox_ctrl
    import can_mbox_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_hit_i,
    input  logic            ts_cap_i,
    input  logic            cs_rd_i,
    input  logic            cs_wr_i,
    input  logic [3:0]      wcode_i,
    input  logic            tmr_rd_i,
    input  logic            flag_clr_i,
    input  logic            mask_wr_i,
    input  logic            mask_val_i,
    input  logic            pend_valid_i,
    input  logic            pend_ovr_i,
    output logic [3:0]      code_o,
    output logic            lock_o,
    output logic            busy_o,
    output logic            accept_o,
    output logic            commit_o,
    output logic            flag_o,
    output logic            mask_o,
    output logic            irq_o,
    output logic [TS_W-1:0] timer_o,
    output logic [TS_W-1:0] ts_shadow_o
);
    logic active;

    // The buffer takes frames in any code other than INACTIVE-like values.
    always_comb begin
        active   = (code_o == CODE_EMPTY) || (code_o == CODE_FULL) ||
                   (code_o == CODE_OVERRUN);
        busy_o   = pend_valid_i && !lock_o;
        accept_o = rx_hit_i && active && !cs_wr_i;
        commit_o = pend_valid_i && !lock_o && !cs_wr_i;
        irq_o    = flag_o && mask_o;
    end

    // Code field: a software write wins; a commit yields FULL or OVERRUN.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_o <= CODE_INACTIVE;
        else if (cs_wr_i)
            code_o <= wcode_i;
        else if (commit_o)
            code_o <= (pend_ovr_i || code_o == CODE_FULL ||
                       code_o == CODE_OVERRUN) ? CODE_OVERRUN : CODE_FULL;
    end

    // Read lock: set by a status read while not busy, cleared by a timer read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_o <= 1'b0;
        else if (tmr_rd_i)
            lock_o <= 1'b0;
        else if (cs_rd_i && !busy_o)
            lock_o <= 1'b1;
    end

    // Interrupt flag: set on commit (priority), cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (commit_o)
            flag_o <= 1'b1;
        else if (flag_clr_i)
            flag_o <= 1'b0;
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= 1'b0;
        else if (mask_wr_i)
            mask_o <= mask_val_i;
    end

    // Free-running timer and the shadow sampled at the timestamp strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_o     <= '0;
            ts_shadow_o <= '0;
        end else begin
            timer_o <= timer_o + 1'b1;
            if (ts_cap_i)
                ts_shadow_o <= timer_o;
        end
    end

    AST_COMMIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> flag_o); // R6
    AST_COMMIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (code_o == CODE_FULL || code_o == CODE_OVERRUN)); // R4
    AST_FULL_OVERRUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && code_o == CODE_FULL) |=> (code_o == CODE_OVERRUN)); // R5
    AST_TIMER_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_rd_i |=> !lock_o); // R8
    AST_BUSY_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rd_i && busy_o && !lock_o) |=> !lock_o); // R12
endmodule

// File: rtl/mbox_store.sv
// Committed frame contents of the mailbox, written only on commit.
// Assumes commit is never raised while the lock input is set.
module mbox_store
    import can_mbox_pkg::*;
#(
    parameter int DW = 512
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit_i,
    input  logic            lock_i,
    input  logic [ID_W-1:0] id_i,
    input  mb_ctl_t         ctl_i,
    input  logic [DW-1:0]   data_i,
    input  logic [TS_W-1:0] ts_i,
    output logic [ID_W-1:0] id_o,
    output mb_ctl_t         ctl_o,
    output logic [DW-1:0]   data_o,
    output logic [TS_W-1:0] ts_o
);
    // Move-in of a held frame into the visible mailbox.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_o   <= '0;
            ctl_o  <= '0;
            data_o <= '0;
            ts_o   <= '0;
        end else if (commit_i) begin
            id_o   <= id_i;
            ctl_o  <= ctl_i;
            data_o <= data_i;
            ts_o   <= ts_i;
        end
    end

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> ($stable(id_o) && $stable(ctl_o) && $stable(ts_o) &&
                    $stable(data_o))); // R7
endmodule

// File: rtl/can_rx_mbox.sv
// Receive mailbox top: decodes CPU register traffic, wires the holding
// register, the sequencer and the store, and drives the read mux.
// Assumes one CPU access per cycle and N_WORDS <= 2**(ADDR_W-1).
module can_rx_mbox
    import can_mbox_pkg::*;
#(
    parameter int DATA_BYTES = 64,
    parameter int ADDR_W     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic                    rx_match,
    input  logic [ID_W-1:0]         rx_id,
    input  logic                    rx_srr,
    input  logic                    rx_ide,
    input  logic                    rx_rtr,
    input  logic                    rx_edl,
    input  logic                    rx_brs,
    input  logic                    rx_esi,
    input  logic [3:0]              rx_dlc,
    input  logic [DATA_BYTES*8-1:0] rx_data,
    input  logic                    ts_cap,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic                    cpu_rd,
    input  logic                    cpu_wr,
    input  logic [31:0]             cpu_wdata,
    output logic [31:0]             cpu_rdata,
    output logic                    irq
);
    localparam int DW      = DATA_BYTES * 8;
    localparam int N_WORDS = DATA_BYTES / 4;
    localparam int WSEL_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam logic [ADDR_W-1:0] A_CS   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_TMR  = ADDR_W'(4);

    logic cs_rd, cs_wr, tmr_rd, flag_clr, mask_wr;
    logic accept, commit, busy, lock, flag, mask;
    logic pend_valid, pend_ovr;
    logic [3:0] code;
    logic [TS_W-1:0] timer, ts_shadow, pend_ts, st_ts;
    logic [ID_W-1:0] pend_id, st_id;
    mb_ctl_t rx_ctl, pend_ctl, st_ctl;
    logic [DW-1:0] pend_data, st_data;
    logic [31:0] dword [N_WORDS];
    logic unused_wdata;

    // Register strobes decoded from the CPU access.
    always_comb begin
        cs_rd    = cpu_rd && (cpu_addr == A_CS);
        cs_wr    = cpu_wr && (cpu_addr == A_CS);
        tmr_rd   = cpu_rd && (cpu_addr == A_TMR);
        flag_clr = cpu_wr && (cpu_addr == A_FLAG) && cpu_wdata[0];
        mask_wr  = cpu_wr && (cpu_addr == A_MASK);
        rx_ctl   = '{srr: rx_srr, ide: rx_ide, rtr: rx_rtr, edl: rx_edl,
                     brs: rx_brs, esi: rx_esi, dlc: rx_dlc};
    end
    assign unused_wdata = ^{cpu_wdata[31:28], cpu_wdata[23:1]};

    mbox_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_hit_i(rx_valid && rx_match),
        .ts_cap_i(ts_cap), .cs_rd_i(cs_rd), .cs_wr_i(cs_wr),
        .wcode_i(cpu_wdata[27:24]), .tmr_rd_i(tmr_rd),
        .flag_clr_i(flag_clr), .mask_wr_i(mask_wr), .mask_val_i(cpu_wdata[0]),
        .pend_valid_i(pend_valid), .pend_ovr_i(pend_ovr),
        .code_o(code), .lock_o(lock), .busy_o(busy), .accept_o(accept),
        .commit_o(commit), .flag_o(flag), .mask_o(mask), .irq_o(irq),
        .timer_o(timer), .ts_shadow_o(ts_shadow)
    );

    mbox_pend #(.DW(DW)) u_pend (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .take_i(commit),
        .drop_i(cs_wr), .id_i(rx_id), .ctl_i(rx_ctl), .data_i(rx_data),
        .ts_i(ts_shadow), .valid_o(pend_valid), .ovr_o(pend_ovr),
        .id_o(pend_id), .ctl_o(pend_ctl), .data_o(pend_data), .ts_o(pend_ts)
    );

    mbox_store #(.DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .lock_i(lock),
        .id_i(pend_id), .ctl_i(pend_ctl), .data_i(pend_data), .ts_i(pend_ts),
        .id_o(st_id), .ctl_o(st_ctl), .data_o(st_data), .ts_o(st_ts)
    );

    // Split the stored payload into CPU-visible data words.
    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        assign dword[k] = st_data[32*k +: 32];
    end

    // Read data multiplexer; data words sit in the upper half of the map.
    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr[ADDR_W-1]) begin
            cpu_rdata = dword[cpu_addr[WSEL_W-1:0]];
        end else begin
            case (cpu_addr)
                A_CS:   cpu_rdata = {st_ctl.edl, st_ctl.brs, st_ctl.esi, 1'b0,
                                     code, busy, st_ctl.srr, st_ctl.ide,
                                     st_ctl.rtr, st_ctl.dlc, st_ts};
                A_ID:   cpu_rdata = {{(32-ID_W){1'b0}}, st_id};
                A_FLAG: cpu_rdata = {31'b0, flag};
                A_MASK: cpu_rdata = {31'b0, mask};
                A_TMR:  cpu_rdata = {{(32-TS_W){1'b0}}, timer};
                default: cpu_rdata = '0;
            endcase
        end
    end

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask && $past(!mask)) |-> !irq); // R6
    AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (code == CODE_INACTIVE && !pend_valid && !cs_wr) |=> !commit); // R1
endmodule

// File: tb/can_rx_mbox_bench.sv
`timescale 1ns/1ps
module can_rx_mbox_bench;
    import can_mbox_pkg::*;
    localparam int DB = 64;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 0, rx_match = 0, ts_cap = 0;
    logic [ID_W-1:0] rx_id = '0;
    mb_ctl_t rx_ctl = '0;
    logic [DB*8-1:0] rx_data = '0;
    logic [AW-1:0] cpu_addr = '0;
    logic cpu_rd = 0, cpu_wr = 0;
    logic [31:0] cpu_wdata = '0, cpu_rdata;
    logic irq;

    int n_chk = 0, n_fail = 0;
    logic [ID_W-1:0] f_id;
    mb_ctl_t f_ctl;
    logic [DB*8-1:0] f_data;
    logic [31:0] rv, tval;
    logic [ID_W-1:0] a_id;
    logic [3:0] mcode;

    always #2.5 clk = ~clk;

    can_rx_mbox u_can_rx_mbox (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_match(rx_match),
        .rx_id(rx_id), .rx_srr(rx_ctl.srr), .rx_ide(rx_ctl.ide),
        .rx_rtr(rx_ctl.rtr), .rx_edl(rx_ctl.edl), .rx_brs(rx_ctl.brs),
        .rx_esi(rx_ctl.esi), .rx_dlc(rx_ctl.dlc), .rx_data(rx_data),
        .ts_cap(ts_cap), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
    );

    function automatic logic [31:0] cs_word(logic [3:0] code, logic busy,
                                            mb_ctl_t c, logic [15:0] ts);
        return {c.edl, c.brs, c.esi, 1'b0, code, busy, c.srr, c.ide, c.rtr,
                c.dlc, ts};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic new_frame();
        f_id  = ID_W'($urandom);
        f_ctl = mb_ctl_t'($urandom);
        for (int k = 0; k < DB / 4; k++) f_data[32*k +: 32] = $urandom;
    endtask

    task automatic send(input logic m);
        rx_id = f_id; rx_ctl = f_ctl; rx_data = f_data;
        rx_match = m; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic stamp();   // returns expected timestamp in tval
        rd(5'd4, tval);
        ts_cap = 1'b1;
        @(negedge clk);
        ts_cap = 1'b0;
        tval = {16'b0, tval[15:0] + 16'd1};
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        rd(5'd0, rv); chk("R1 status after reset", rv, 32'h0);
        rd(5'd4, rv);
        rd(5'd2, rv); chk("R1 flag after reset", rv, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        // R1 inactive buffer ignores frames
        new_frame(); send(1'b1); idle(); idle();
        rd(5'd2, rv); chk("R1 inactive ignores frame", rv, 32'h0);
        // R2 activate, mismatch ignored
        wr(5'd3, 32'h1);
        wr(5'd0, {4'b0, CODE_EMPTY, 24'b0});
        send(1'b0); idle(); idle();
        rd(5'd2, rv); chk("R2 mismatch flag", rv, 32'h0);
        rd(5'd0, rv); chk("R2 mismatch code", {28'b0, rv[27:24]}, {28'b0, CODE_EMPTY});
        rd(5'd4, rv);
        // R3/R4/R12 first frame
        new_frame(); stamp(); send(1'b1);
        a_id = f_id;
        rd(5'd0, rv); chk("R4 busy during move-in", {31'b0, rv[23]}, 32'h1);
        chk("R12 code before commit", {28'b0, rv[27:24]}, {28'b0, CODE_EMPTY});
        rd(5'd0, rv); chk("R3 R4 status word", rv, cs_word(CODE_FULL, 1'b0, f_ctl, tval[15:0]));
        chk("R6 irq with mask", {31'b0, irq}, 32'h1);
        rd(5'd1, rv); chk("R3 identifier", rv, {3'b0, f_id});
        rd(5'd16, rv); chk("R3 data word 0", rv, f_data[31:0]);
        rd(5'd31, rv); chk("R3 data word 15", rv, f_data[511:480]);
        // R7 locked: new frame held
        new_frame(); send(1'b1); idle();
        rd(5'd1, rv); chk("R7 id unchanged while locked", rv, {3'b0, a_id});
        rd(5'd0, rv); chk("R7 code unchanged while locked", {28'b0, rv[27:24]}, {28'b0, CODE_FULL});
        // R8 unlock moves held frame
        rd(5'd4, rv);
        rd(5'd0, rv); chk("R8 busy after unlock", {31'b0, rv[23]}, 32'h1);
        rd(5'd0, rv); chk("R5 full becomes overrun", {28'b0, rv[27:24]}, {28'b0, CODE_OVERRUN});
        rd(5'd1, rv); chk("R8 held frame moved in", rv, {3'b0, f_id});
        rd(5'd4, rv);
        // R6 write-one-to-clear
        wr(5'd2, 32'h1);
        rd(5'd2, rv); chk("R6 flag cleared", rv, 32'h0);
        chk("R6 irq cleared", {31'b0, irq}, 32'h0);
        // R6 set wins over clear
        wr(5'd0, {4'b0, CODE_EMPTY, 24'b0});
        new_frame(); send(1'b1);
        wr(5'd2, 32'h1);
        rd(5'd2, rv); chk("R6 set beats clear", rv, 32'h1);
        // R11 code stays FULL after service
        rd(5'd0, rv); chk("R11 full before service", {28'b0, rv[27:24]}, {28'b0, CODE_FULL});
        rd(5'd4, rv); idle();
        rd(5'd0, rv); chk("R11 full after service", {28'b0, rv[27:24]}, {28'b0, CODE_FULL});
        rd(5'd4, rv);
        // R9 replacement while held
        wr(5'd0, {4'b0, CODE_EMPTY, 24'b0});
        rd(5'd0, rv);
        new_frame(); send(1'b1);
        new_frame(); send(1'b1);
        rd(5'd4, rv); idle();
        rd(5'd0, rv); chk("R9 replaced frame overruns", {28'b0, rv[27:24]}, {28'b0, CODE_OVERRUN});
        rd(5'd1, rv); chk("R9 newest frame kept", rv, {3'b0, f_id});
        a_id = f_id;
        rd(5'd4, rv);
        // R10 status write drops held frame
        wr(5'd2, 32'h1);
        wr(5'd0, {4'b0, CODE_EMPTY, 24'b0});
        rd(5'd0, rv);
        new_frame(); send(1'b1);
        wr(5'd0, {4'b0, CODE_EMPTY, 24'b0});
        rd(5'd4, rv); idle(); idle();
        rd(5'd2, rv); chk("R10 dropped frame no flag", rv, 32'h0);
        rd(5'd0, rv); chk("R10 code stays written", {28'b0, rv[27:24]}, {28'b0, CODE_EMPTY});
        rd(5'd1, rv); chk("R10 id unchanged", rv, {3'b0, a_id});
        rd(5'd4, rv);
        // R6 mask low keeps irq low
        wr(5'd3, 32'h0);
        new_frame(); send(1'b1); idle(); idle();
        rd(5'd2, rv); chk("R6 flag with mask low", rv, 32'h1);
        chk("R6 irq masked", {31'b0, irq}, 32'h0);
        mcode = CODE_FULL;
        a_id = f_id;
        // Random mix of locked and unlocked receptions
        for (int it = 0; it < 60; it++) begin
            logic lk, m, em;
            int w;
            lk = 1'($urandom); m = ($urandom % 4) != 0; em = 1'($urandom);
            w = $urandom % (DB / 4);
            wr(5'd2, 32'h1);
            if (em) begin
                wr(5'd0, {4'b0, CODE_EMPTY, 24'b0});
                mcode = CODE_EMPTY;
            end
            new_frame(); stamp();
            if (lk) begin
                rd(5'd0, rv); send(m); rd(5'd4, rv);
            end else begin
                send(m);
            end
            idle(); idle();
            if (m) begin
                mcode = (mcode == CODE_EMPTY) ? CODE_FULL : CODE_OVERRUN;
                a_id = f_id;
            end
            rd(5'd0, rv);
            chk("R4 R5 random code", {28'b0, rv[27:24]}, {28'b0, mcode});
            if (m) chk("R3 random stamp", {16'b0, rv[15:0]}, tval);
            rd(5'd1, rv); chk("R3 R8 random id", rv, {3'b0, a_id});
            if (m) begin
                rd(AW'(16 + w), rv); chk("R3 random data word", rv, f_data[32*w +: 32]);
            end
            rd(5'd2, rv); chk("R2 R6 random flag", rv, {31'b0, m});
            rd(5'd4, rv);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule